// File: doc/BRIEF.md
# Receive Character Queue with Error Reporting

This block is the receive-side character queue of a serial channel. The bit-level receiver pushes each completed character into it, together with three per-character flags: break detected, framing error and parity error. The host reads the oldest character from the top of the queue and removes it with a pop strobe. A mode input selects how the three error flags appear to the host.

In per-character mode the flags belong to the character currently at the top. In block mode they are a sticky OR over every character accepted since the last error-clear command. A push into a full queue is dropped and raises a sticky overrun flag.

The block also drives an active-low request-to-send output. The host sets its base level. When automatic flow control is enabled, a start bit seen while the queue is full negates it, and it is released as soon as a slot becomes free.

Top module: `rx_err_fifo`

## Requirements
- R1: Out of reset the queue is empty (`empty_o`=1, `full_o`=0). It holds 8 characters, and `full_o` rises after the 8th accepted push.
- R2: `top_data_o` shows the oldest stored character, and characters leave in push order. It reads 0 while the queue is empty.
- R3: A push while full with no pop in the same cycle is discarded, and the stored contents are unchanged. `overrun_o` is set from the next cycle and stays set until a cycle with `err_clr_i`=1. If an overrun and a clear happen in the same cycle, the overrun wins.
- R4: A push and a pop in the same cycle on a full queue are both accepted. The queue stays full and the new character is queued last.
- R5: A pop while empty has no effect.
- R6: With `block_mode_i`=0, `stat_brk_o`, `stat_frm_o` and `stat_par_o` equal the break, framing and parity flags stored with the top character.
- R7: With `block_mode_i`=0 and the queue empty, all three status outputs are 0.
- R8: With `block_mode_i`=1, each status output is the OR of that flag over all characters accepted since the last clear. A push updates it from the next cycle, and popping characters does not lower it.
- R9: `err_clr_i` zeroes the block accumulators and `overrun_o`. The flags of a character accepted in the same cycle as the clear are still accumulated.
- R10: Automatic negation happens when `auto_rts_en_i`=1, `rts_on_i`=1 and the queue is full. A cycle with `start_det_i`=1 under those conditions drives `rts_no` high from the next cycle.
- R11: `rts_no` returns low in the same cycle the queue stops being full, provided `rts_on_i`=1.
- R12: With `rts_on_i`=0, `rts_no` is 1. With `rts_on_i`=1 and no automatic negation armed, `rts_no` is 0.
- R13: `start_det_i` while the queue is not full leaves `rts_no` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Character push strobe from the receiver |
| push_data_i | input | 8 | Character data |
| push_brk_i | input | 1 | Break flag of the pushed character |
| push_frm_i | input | 1 | Framing-error flag of the pushed character |
| push_par_i | input | 1 | Parity-error flag of the pushed character |
| start_det_i | input | 1 | Start-bit-detected pulse |
| pop_i | input | 1 | Host pop strobe |
| block_mode_i | input | 1 | 1 selects sticky block-OR status, 0 selects per-character status |
| auto_rts_en_i | input | 1 | Enables automatic RTS negation |
| rts_on_i | input | 1 | Host RTS level: 1 asserts RTS (`rts_no` low) |
| err_clr_i | input | 1 | Clears the block accumulators and the overrun flag |
| top_data_o | output | 8 | Character at the top of the queue |
| stat_brk_o | output | 1 | Break status |
| stat_frm_o | output | 1 | Framing-error status |
| stat_par_o | output | 1 | Parity-error status |
| overrun_o | output | 1 | Sticky overrun flag |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| rts_no | output | 1 | Request to send, active low |

## Verification
The assertions assume that the mode and enable inputs change only between clearly separated phases, not during a check window. They also assume that `start_det_i` is a pulse the receiver would raise alongside, or ahead of, a push. The properties that span one cycle are written so that they hold even if the mode inputs move. The stimulus holds the mode, auto-enable and RTS level constant within each phase and only changes them on idle cycles. Pops are issued to the empty queue only on purpose, and overruns are created only on purpose.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  localparam rx_flags_t FLAGS_NONE = '{brk: 1'b0, frm: 1'b0, par: 1'b0};
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  rx_flags_t         wr_flags_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output rx_flags_t         rd_flags_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] data_q  [DEPTH];
  rx_flags_t         flags_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        flags_q[g] <= FLAGS_NONE;
      end else if (wr_i && (wr_ptr_q == PTR_W'(g))) begin
        data_q[g]  <= wr_data_i;
        flags_q[g] <= wr_flags_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o     = (cnt_q == CNT_FULL);
  assign empty_o    = (cnt_q == '0);
  assign rd_data_o  = data_q[rd_ptr_q];
  assign rd_flags_o = flags_q[rd_ptr_q];
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rx_err_fifo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      block_mode_i,
  input  logic      empty_i,
  input  rx_flags_t top_flags_i,
  input  logic      push_ok_i,
  input  rx_flags_t push_flags_i,
  input  logic      ovr_evt_i,
  input  logic      clr_i,
  output rx_flags_t stat_o,
  output logic      overrun_o
);
  rx_flags_t acc_q, acc_base;
  logic      ovr_q;

  // clear first, then fold in a same-cycle push
  always_comb begin
    acc_base = clr_i ? FLAGS_NONE : acc_q;
    if (push_ok_i) acc_base = acc_base | push_flags_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= FLAGS_NONE;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= acc_base;
      if (ovr_evt_i)  ovr_q <= 1'b1;
      else if (clr_i) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    if (block_mode_i)  stat_o = acc_q;
    else if (empty_i)  stat_o = FLAGS_NONE;
    else               stat_o = top_flags_i;
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/rx_rts_ctrl.sv
module rx_rts_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic rts_on_i,
  input  logic full_i,
  input  logic start_det_i,
  output logic rts_no
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               armed_q <= 1'b0;
    else if (!full_i || !auto_en_i)            armed_q <= 1'b0;
    else if (start_det_i && rts_on_i)          armed_q <= 1'b1;
  end

  // release is combinational on full so a freed slot lowers RTSN at once
  assign rts_no = !rts_on_i || (armed_q && full_i && auto_en_i);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_brk_i,
  input  logic              push_frm_i,
  input  logic              push_par_i,
  input  logic              start_det_i,
  input  logic              pop_i,
  input  logic              block_mode_i,
  input  logic              auto_rts_en_i,
  input  logic              rts_on_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] top_data_o,
  output logic              stat_brk_o,
  output logic              stat_frm_o,
  output logic              stat_par_o,
  output logic              overrun_o,
  output logic              full_o,
  output logic              empty_o
  ,output logic             rts_no
);
  rx_flags_t         push_flags, top_flags, stat;
  logic [DATA_W-1:0] top_data;
  logic              full, empty, pop_ok, push_ok, ovr_evt;

  assign push_flags = '{brk: push_brk_i, frm: push_frm_i, par: push_par_i};
  assign pop_ok     = pop_i && !empty;
  assign push_ok    = push_i && (!full || pop_ok);
  assign ovr_evt    = push_i && full && !pop_ok;

  rx_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (push_ok),
    .wr_data_i  (push_data_i),
    .wr_flags_i (push_flags),
    .rd_i       (pop_ok),
    .rd_data_o  (top_data),
    .rd_flags_o (top_flags),
    .full_o     (full),
    .empty_o    (empty)
  );

  rx_err_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .block_mode_i (block_mode_i),
    .empty_i      (empty),
    .top_flags_i  (top_flags),
    .push_ok_i    (push_ok),
    .push_flags_i (push_flags),
    .ovr_evt_i    (ovr_evt),
    .clr_i        (err_clr_i),
    .stat_o       (stat),
    .overrun_o    (overrun_o)
  );

  rx_rts_ctrl u_rts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_en_i   (auto_rts_en_i),
    .rts_on_i    (rts_on_i),
    .full_i      (full),
    .start_det_i (start_det_i),
    .rts_no      (rts_no)
  );

  assign top_data_o = empty ? '0 : top_data;
  assign stat_brk_o = stat.brk;
  assign stat_frm_o = stat.frm;
  assign stat_par_o = stat.par;
  assign full_o     = full;
  assign empty_o    = empty;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic push_i,
  input logic pop_i,
  input logic start_det_i,
  input logic block_mode_i,
  input logic auto_rts_en_i,
  input logic rts_on_i,
  input logic err_clr_i,
  input logic stat_brk_o,
  input logic stat_frm_o,
  input logic stat_par_o,
  input logic overrun_o,
  input logic full_o,
  input logic empty_o,
  input logic rts_no
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R1
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> overrun_o); // R3
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !err_clr_i |=> overrun_o); // R3
  AST_FULL_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && pop_i |=> full_o); // R4
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o); // R5
  AST_CHAR_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !block_mode_i && empty_o |-> !(stat_brk_o || stat_frm_o || stat_par_o)); // R7
  AST_BLK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_mode_i && stat_brk_o && !err_clr_i |=> (!block_mode_i || stat_brk_o)); // R8
  AST_CLR_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !push_i |=> (!block_mode_i || !(stat_brk_o || stat_frm_o || stat_par_o))); // R9
  AST_RTS_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rts_en_i && rts_on_i && full_o && start_det_i && !pop_i
    |=> (!full_o || !auto_rts_en_i || rts_no)); // R10
  AST_RTS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_on_i && !full_o |-> !rts_no); // R11
  AST_RTS_MANUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_on_i |-> rts_no); // R12
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .push_i        (push_i),
  .pop_i         (pop_i),
  .start_det_i   (start_det_i),
  .block_mode_i  (block_mode_i),
  .auto_rts_en_i (auto_rts_en_i),
  .rts_on_i      (rts_on_i),
  .err_clr_i     (err_clr_i),
  .stat_brk_o    (stat_brk_o),
  .stat_frm_o    (stat_frm_o),
  .stat_par_o    (stat_par_o),
  .overrun_o     (overrun_o),
  .full_o        (full_o),
  .empty_o       (empty_o),
  .rts_no        (rts_no)
);

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 0, pop_i = 0, start_det_i = 0, err_clr_i = 0;
  logic [7:0] push_data_i = '0;
  logic       push_brk_i = 0, push_frm_i = 0, push_par_i = 0;
  logic       block_mode_i = 0, auto_rts_en_i = 0, rts_on_i = 1;
  logic [7:0] top_data_o;
  logic       stat_brk_o, stat_frm_o, stat_par_o, overrun_o, full_o, empty_o, rts_no;

  int n_chk = 0, n_bad = 0;
  logic [10:0] sb_q[$];   // {flags[2:0], data[7:0]}
  logic [2:0]  exp_acc = '0;
  logic        exp_ovr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_fifo dut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_data_i(push_data_i),
    .push_brk_i(push_brk_i), .push_frm_i(push_frm_i), .push_par_i(push_par_i),
    .start_det_i(start_det_i), .pop_i(pop_i), .block_mode_i(block_mode_i),
    .auto_rts_en_i(auto_rts_en_i), .rts_on_i(rts_on_i), .err_clr_i(err_clr_i),
    .top_data_o(top_data_o), .stat_brk_o(stat_brk_o), .stat_frm_o(stat_frm_o),
    .stat_par_o(stat_par_o), .overrun_o(overrun_o), .full_o(full_o),
    .empty_o(empty_o), .rts_no(rts_no)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares the departing character against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && pop_i && !empty_o) begin
      if (sb_q.size() == 0) begin
        check("R2 unexpected pop data", 32'(top_data_o), 32'hFFFF);
      end else begin
        check("R2 top data", 32'(top_data_o), 32'(sb_q[0][7:0]));
        if (!block_mode_i)
          check("R6 top flags", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 32'(sb_q[0][10:8]));
        void'(sb_q.pop_front());
      end
    end
  end

  // driver: one cycle of stimulus, scoreboard and model updated here
  task automatic step(input logic push, input logic [7:0] d, input logic [2:0] f,
                      input logic pop, input logic sd, input logic clr);
    logic acc_ok;
    @(posedge clk); #1;
    push_i = push; push_data_i = d; {push_brk_i, push_frm_i, push_par_i} = f;
    pop_i = pop; start_det_i = sd; err_clr_i = clr;
    acc_ok = push && (sb_q.size() < DEPTH || (pop && sb_q.size() > 0));
    if (acc_ok) sb_q.push_back({f, d});
    exp_acc = (clr ? 3'b000 : exp_acc) | (acc_ok ? f : 3'b000);
    if (push && sb_q.size() >= DEPTH && !acc_ok) exp_ovr = 1'b1;
    else if (clr) exp_ovr = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 8'h00, 3'b000, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset empty", 32'(empty_o), 1);
    check("R1 reset not full", 32'(full_o), 0);
    check("R2 empty data zero", 32'(top_data_o), 0);
    check("R7 reset status", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 0);
    check("R12 reset rts", 32'(rts_no), 0);

    // fill with varied flags
    auto_rts_en_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h30 + i), 3'(i), 0, 0, 0);
    idle();
    check("R1 full after 8", 32'(full_o), 1);
    check("R6 top flags char mode", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 0);
    check("R2 top oldest", 32'(top_data_o), 32'h30);
    check("R11 no start yet", 32'(rts_no), 0);

    // overrun: discard
    step(1, 8'hEE, 3'b111, 0, 0, 0);
    idle();
    check("R3 overrun set", 32'(overrun_o), 1);
    check("R3 still full", 32'(full_o), 1);
    check("R3 top unchanged", 32'(top_data_o), 32'h30);

    // start bit while full
    step(0, 8'h00, 3'b000, 0, 1, 0);
    idle();
    check("R10 rts negated", 32'(rts_no), 1);
    // pop: rts released the same cycle full drops
    step(0, 8'h00, 3'b000, 1, 0, 0);
    step(0, 8'h00, 3'b000, 0, 0, 0);
    check("R11 rts released", 32'(rts_no), 0);
    check("R11 not full", 32'(full_o), 0);

    // refill to full, then push+pop
    step(1, 8'h50, 3'b101, 0, 0, 0);
    idle();
    check("R4 full again", 32'(full_o), 1);
    step(1, 8'h51, 3'b010, 1, 0, 0);
    idle();
    check("R4 full after push+pop", 32'(full_o), 1);
    check("R4 no overrun change", 32'(overrun_o), 1);

    // drain, monitor checks order and flags
    while (sb_q.size() > 0) step(0, 8'h00, 3'b000, 1, 0, 0);
    idle();
    check("R2 drained empty", 32'(empty_o), 1);
    step(0, 8'h00, 3'b000, 1, 0, 0);
    idle();
    check("R5 empty pop empty", 32'(empty_o), 1);
    check("R5 empty pop not full", 32'(full_o), 0);
    check("R7 empty status", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 0);
    check("R2 empty data", 32'(top_data_o), 0);

    // block mode
    step(0, 8'h00, 3'b000, 0, 0, 1);
    block_mode_i = 1'b1;
    idle();
    check("R9 overrun cleared", 32'(overrun_o), 0);
    check("R9 acc cleared", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 0);
    step(1, 8'h61, 3'b001, 0, 0, 0);
    check("R8 not yet visible", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 0);
    step(1, 8'h62, 3'b000, 0, 0, 0);
    check("R8 after first", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 32'(exp_acc));
    step(1, 8'h63, 3'b100, 0, 0, 0);
    while (sb_q.size() > 0) step(0, 8'h00, 3'b000, 1, 0, 0);
    idle();
    check("R8 sticky after pops", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 32'(3'b101));
    check("R8 model", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 32'(exp_acc));
    step(1, 8'h64, 3'b010, 0, 0, 1);
    idle();
    check("R9 clear keeps same-cycle push", 32'({stat_brk_o, stat_frm_o, stat_par_o}), 32'(3'b010));
    step(0, 8'h00, 3'b000, 1, 0, 0);
    idle();

    // manual rts and start bit when not full
    block_mode_i = 1'b0;
    step(1, 8'h70, 3'b000, 0, 1, 0);
    idle();
    check("R13 start not full", 32'(rts_no), 0);
    rts_on_i = 1'b0;
    idle();
    check("R12 manual off", 32'(rts_no), 1);
    for (int i = 0; i < DEPTH - 1; i++) step(1, 8'(8'h71 + i), 3'b000, 0, 1, 0);
    idle();
    check("R1 full again", 32'(full_o), 1);
    rts_on_i = 1'b1;
    idle();
    check("R12 not armed while off", 32'(rts_no), 0);
    while (sb_q.size() > 0) step(0, 8'h00, 3'b000, 1, 0, 0);
    idle();
    check("R2 final empty", 32'(empty_o), 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule